// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block brings a device out of reset with its configuration settings in place. At the end of the external reset it captures a set of strap pins and turns them into default values for a small bank of 16-bit configuration words. It then reads a 64-word by 16-bit serial EEPROM over a three-wire serial link with a select line. Word 0 must hold the signature 0x55AA. When it does, words 1 to 11 are read in turn and replace the defaults. When it does not, reading stops after word 0 and the strapped defaults stay in force.

The rest of the device is held in reset until loading ends. The EEPROM pins are shared with strap and LED functions. An output enable marks the period in which the loader drives them, and it drops once loading is over. The serial clock comes from the system clock. Its half period is 2^`SK_HALF_LOG2` system cycles. The default of 128 cycles at 50 MHz gives a serial period of 5.12 µs.

Top module: `cfg_loader`

## Requirements
- R1: The strap inputs are captured once, on the first clock after the synchronised reset release. Later changes on the strap inputs have no effect on the configuration words.
- R2: `core_rst_n` is low from reset until the last EEPROM word has been taken, and it is low during every serial clock pulse. `ee_oe` is low during reset, high from the cycle after the strap capture, and low again once loading ends.
- R3: Every read transaction sends the bits 1, 1, 0 on `ee_di`, followed by the six-bit word address with its MSB first. It then clocks in 16 data bits, D15 first.
- R4: Inside a transaction, successive rising edges of `ee_sk` are 2^(`SK_HALF_LOG2`+1) system clocks apart, with the low half first.
- R5: `ee_di` changes only while `ee_sk` is low.
- R6: If word 0 is not exactly 0x55AA, only one transaction takes place, and every configuration word keeps its strapped default.
- R7: If word 0 is 0x55AA, words 1 to 11 are read in ascending address order. Configuration word k (k = 1..11) then equals EEPROM word k, and `cfg_words_o[16k-1:16k-16]` carries word k.
- R8: `ee_cs` stays low for at least one full serial clock period before each transaction.
- R9: Once `core_rst_n` is high it stays high, and `ee_cs`, `ee_sk`, `ee_di` and `ee_oe` stay low.
- R10: The bit that the EEPROM drives on `ee_do` before D15 is ignored, whatever its value.
- R11: The strapped defaults are as follows. Word 1 = {14'b0, strap[1:0]}. Word 2 = {8'b0, strap[7:2], 2'b00}. Word 7 = 0x0077. Word 10 = 0x0080. All other words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| strap_i | input | 8 | Strap pin values, captured at the end of reset |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_oe | output | 1 | High while the loader drives the shared pins |
| cfg_words_o | output | 176 | Configuration words 1..11, word k at bits 16k-1:16k-16 |
| core_rst_n | output | 1 | Reset for the rest of the device, released when loading ends |

## Verification
The reset synchroniser has two stages, so the strap capture falls on the third rising clock after `rst_n` is released. The bench therefore changes the straps only after the fourth falling edge, which makes any late capture show up in the configuration words. A transaction lasts 25 serial periods plus one gap period. `ee_do` is sampled in the last system cycle of each high phase, so the EEPROM model updates its data on rising serial edges, one edge after the dummy bit. The model timestamps pin edges to check the serial period, the chip-select gap and the timing of `ee_di` edges. The configuration words and the pin levels are read at a falling clock edge once `core_rst_n` has risen.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int STRAP_W = 8;
  localparam logic [WORD_W-1:0] SIGNATURE = 16'h55AA;
  localparam logic [2:0] READ_CMD = 3'b110;

  typedef enum logic [1:0] {S_LATCH, S_GAP, S_XFER, S_DONE} ld_state_t;

  // default word value derived from the captured straps
  function automatic logic [WORD_W-1:0] strap_default(input int idx,
                                                      input logic [STRAP_W-1:0] strap);
    logic [WORD_W-1:0] v;
    v = '0;
    if (idx == 1)       v = {14'b0, strap[1:0]};
    else if (idx == 2)  v = {8'b0, strap[7:2], 2'b00};
    else if (idx == 7)  v = 16'h0077;
    else if (idx == 10) v = 16'h0080;
    return v;
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
`timescale 1ns/1ps
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cfg_regfile.sv
`timescale 1ns/1ps
module cfg_regfile
  import cfg_loader_pkg::*;
#(
  parameter int NUM_CFG = 11,
  parameter int IDX_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_def,
  input  logic [STRAP_W-1:0]        strap_i,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [WORD_W-1:0]         wr_data,
  output logic [NUM_CFG*WORD_W-1:0] words_o
);
  for (genvar g = 1; g <= NUM_CFG; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_q <= '0;
      else if (load_def) word_q <= strap_default(g, strap_i);
      else if (hit)      word_q <= wr_data;
    end

    assign words_o[g*WORD_W-1 -: WORD_W] = word_q;
  end

  // R7: writes only address an existing configuration word
  assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx >= IDX_W'(1)) && (wr_idx <= IDX_W'(NUM_CFG)));
  // R1: the strap capture and an EEPROM write never coincide
  assert_def_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_def |-> !wr_en);
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SK_HALF_LOG2 = 7,
  parameter int NUM_CFG      = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                strap_i,
  input  logic                      ee_do,
  output logic                      ee_cs,
  output logic                      ee_sk,
  output logic                      ee_di,
  output logic                      ee_oe,
  output logic [NUM_CFG*16-1:0]     cfg_words_o,
  output logic                      core_rst_n
);
  localparam int CNT_W     = SK_HALF_LOG2 + 1;
  localparam int CMD_BITS  = 3 + ADDR_W;
  localparam int SLOT_W    = 5;
  localparam int IDX_W     = $clog2(NUM_CFG + 1);
  localparam logic [SLOT_W-1:0] CMD_SLOTS = SLOT_W'(CMD_BITS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CMD_BITS + WORD_W - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_CFG);

  logic                rst_sync_n;
  ld_state_t           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [WORD_W-1:0]   shift_q, shift_d;
  logic                done_q, done_d;
  logic                load_def, wr_en, cnt_end;
  logic [WORD_W-1:0]   word_nxt;
  logic [CMD_BITS-1:0] cmd, cmd_sh;

  cfg_rst_sync u_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign cnt_end  = &cnt_q;
  assign word_nxt = {shift_q[WORD_W-2:0], ee_do};
  assign cmd      = {READ_CMD, {(ADDR_W-IDX_W){1'b0}}, idx_q};
  assign cmd_sh   = cmd << slot_q;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    slot_d   = slot_q;
    idx_d    = idx_q;
    shift_d  = shift_q;
    done_d   = done_q;
    load_def = 1'b0;
    wr_en    = 1'b0;
    case (state_q)
      S_LATCH: begin
        load_def = 1'b1;
        cnt_d    = '0;
        state_d  = S_GAP;
      end
      S_GAP: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_end) begin
          slot_d  = '0;
          state_d = S_XFER;
        end
      end
      S_XFER: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_end) begin
          if (slot_q >= CMD_SLOTS) shift_d = word_nxt;
          if (slot_q == LAST_SLOT) begin
            if (idx_q == '0) begin
              if (word_nxt == SIGNATURE) begin
                idx_d   = idx_q + 1'b1;
                state_d = S_GAP;
              end else begin
                done_d  = 1'b1;
                state_d = S_DONE;
              end
            end else begin
              wr_en = 1'b1;
              if (idx_q == LAST_IDX) begin
                done_d  = 1'b1;
                state_d = S_DONE;
              end else begin
                idx_d   = idx_q + 1'b1;
                state_d = S_GAP;
              end
            end
          end else begin
            slot_d = slot_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = S_DONE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_LATCH;
      cnt_q   <= '0;
      slot_q  <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      done_q  <= done_d;
    end
  end

  assign ee_cs      = (state_q == S_XFER);
  assign ee_sk      = (state_q == S_XFER) && cnt_q[CNT_W-1];
  assign ee_di      = (state_q == S_XFER) && (slot_q < CMD_SLOTS) && cmd_sh[CMD_BITS-1];
  assign ee_oe      = (state_q == S_GAP) || (state_q == S_XFER);
  assign core_rst_n = done_q;

  cfg_regfile #(.NUM_CFG(NUM_CFG), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .load_def(load_def), .strap_i(strap_i),
    .wr_en(wr_en), .wr_idx(idx_q), .wr_data(word_nxt), .words_o(cfg_words_o)
  );

  // assertion-only counter of cycles with chip select low
  logic [CNT_W:0] cs_low_cnt;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)           cs_low_cnt <= '0;
    else if (ee_cs)            cs_low_cnt <= '0;
    else if (cs_low_cnt != '1) cs_low_cnt <= cs_low_cnt + 1'b1;
  end

  assert_di_low_sk_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(ee_di) |-> !ee_sk);
  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ee_cs) |-> cs_low_cnt >= (CNT_W+1)'(2 << SK_HALF_LOG2));
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_rst_n |=> core_rst_n);
  assert_quiet_done_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_rst_n |-> !ee_cs && !ee_sk && !ee_di && !ee_oe);
  assert_hold_core_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ee_cs |-> !core_rst_n && ee_oe);
endmodule

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
  localparam int LOG2  = 2;
  localparam int NC    = 11;
  localparam int PER   = 2 << LOG2;
  localparam int TCLK  = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ee_do, ee_cs, ee_sk, ee_di, ee_oe, core_rst_n;
  logic [7:0] strap;
  logic [NC*16-1:0] cfg;

  cfg_loader #(.SK_HALF_LOG2(LOG2), .NUM_CFG(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .ee_do(ee_do), .ee_cs(ee_cs),
    .ee_sk(ee_sk), .ee_di(ee_di), .ee_oe(ee_oe), .cfg_words_o(cfg),
    .core_rst_n(core_rst_n));

  int total = 0, bad = 0;
  logic [15:0] mem [64];
  logic dummy_val;
  int bitcnt, txn, addr_err, per_err, gap_err, di_err, rst_err, post_act;
  logic [8:0] inbits;
  time last_rise, cs_fall_t;

  // EEPROM model
  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (bitcnt > 0 && ($time - last_rise) != PER*TCLK) per_err++;
      last_rise = $time;
      if (core_rst_n) rst_err++;
      if (bitcnt < 9) begin
        inbits = {inbits[7:0], ee_di};
        bitcnt++;
        if (bitcnt == 9) begin
          if (inbits != {3'b110, 6'(txn)}) addr_err++;
          ee_do = dummy_val;
        end
      end else if (bitcnt < 25) begin
        ee_do = mem[inbits[5:0]][24-bitcnt];
        bitcnt++;
        if (bitcnt == 25) txn++;
      end
    end
  end
  always @(negedge ee_cs) begin bitcnt = 0; cs_fall_t = $time; ee_do = 1'b0; end
  always @(posedge ee_cs) if (($time - cs_fall_t) < PER*TCLK) gap_err++;
  always @(ee_di) if (ee_sk) di_err++;
  always @(ee_cs or ee_sk or ee_di) post_act++;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_def(input int k, input logic [7:0] s);
    case (k)
      1:  return {14'b0, s[1:0]};
      2:  return {8'b0, s[7:2], 2'b00};
      7:  return 16'h0077;
      10: return 16'h0080;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic run_load(input logic [7:0] s, input logic [15:0] w0,
                          input logic [15:0] seed, input logic dv);
    int n;
    logic good;
    good = (w0 == 16'h55AA);
    for (int a = 0; a < 64; a++) mem[a] = 16'(a * 16'h2F1D) ^ seed;
    mem[0] = w0;
    dummy_val = dv;
    txn = 0; addr_err = 0; per_err = 0; gap_err = 0; di_err = 0; rst_err = 0;
    rst_n = 1'b0; strap = s; ee_do = 1'b0; cs_fall_t = $time;
    repeat (3) @(negedge clk);
    chk("R2 reset core_rst_n", int'(core_rst_n), 0);
    chk("R2 reset oe", int'(ee_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    strap = ~s;                       // after capture: must not matter (R1)
    chk("R2 oe during load", int'(ee_oe), 1);
    chk("R2 core held", int'(core_rst_n), 0);
    n = 0;
    while (!core_rst_n && n < 6000) begin @(negedge clk); n++; end
    chk("R2 load finishes", int'(core_rst_n), 1);
    chk(good ? "R7 transaction count" : "R6 transaction count", txn, good ? 12 : 1);
    chk("R3 command and address bits", addr_err, 0);
    chk("R4 serial clock period", per_err, 0);
    chk("R5 di only with sk low", di_err, 0);
    chk("R8 chip select gap", gap_err, 0);
    chk("R2 core reset during sk", rst_err, 0);
    for (int k = 1; k <= NC; k++)
      chk(good ? "R7 R10 loaded word" : "R1 R6 R11 strap default",
          int'(cfg[k*16-1 -: 16]), int'(good ? mem[k] : exp_def(k, s)));
    post_act = 0;
    repeat (3*PER) @(negedge clk);
    chk("R9 no pin activity", post_act, 0);
    chk("R9 pins idle", int'({ee_cs, ee_sk, ee_di, ee_oe}), 0);
    chk("R9 core stays released", int'(core_rst_n), 1);
  endtask

  initial begin
    logic [15:0] sigs [4];
    sigs[0] = 16'h55AB; sigs[1] = 16'hAA55; sigs[2] = 16'h0000; sigs[3] = 16'hFFFF;
    rst_n = 1'b0; strap = 8'h00; ee_do = 1'b0; dummy_val = 1'b0; bitcnt = 0; inbits = '0;
    last_rise = 0; cs_fall_t = 0;
    run_load(8'hA5, 16'h55AA, 16'h0000, 1'b0);
    run_load(8'h3C, 16'h55AA, 16'hFFFF, 1'b1);   // R10 dummy driven high
    run_load(8'h00, 16'h55AA, 16'h5A5A, 1'b1);
    // near-exhaustive strap sweep with a wrong signature (R1, R6, R11)
    for (int s = 0; s < 256; s++) begin
      if (s < 16) run_load(8'(s), 16'h55AA ^ (16'h1 << s), 16'h1234, s[0]);
      else        run_load(8'(s), sigs[s % 4], 16'h4321, s[1]);
    end
    run_load(8'hFF, 16'h55AA, 16'hC3C3, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule